// File: doc/BRIEF.md
# Word-Serial Montgomery Reduction Engine

This block takes a double-width integer `x`, an odd modulus `q` of `N_WORDS` 32-bit words and the word-level constant `mu = -q^-1 mod 2^32`. It returns an `N_WORDS`-word value `z` congruent to `x * 2^(-32*N_WORDS)` modulo `q`. The result is built column by column: every output column gathers all partial products `z_j * q_k` whose word indices sum to that column. A single 32x32 multiplier feeds a three-word accumulator. In the lower half of the columns a reduction word is derived from the accumulator and `mu`. In the upper half the accumulator low word becomes a result word.

The block serves a long chain of modular multiplications whose operands stay in the redundant range `[0, 2q)`. The modulus must meet `4q < 2^(32*N_WORDS)`, so the output always stays below `2q` and can be fed straight back in. The engine never applies a trailing subtraction of `q`. A caller loads all operands with a single-cycle `start`, waits for the one-cycle `done` and reads `zOut`. `zOut` holds that value until the next completion.

Top module: `mont_redc`

## Requirements
- R1: While reset is held and right after it, `busy` and `done` are 0 and `zOut` is all zeros.
- R2: `start` is accepted only when both `busy` and `done` are 0. The operands are captured on that edge, and `busy` is 1 in the following cycle.
- R3: For a modulus meeting the input limits, `(zOut * 2^(32*N_WORDS)) mod q` equals `x mod q`.
- R4: `zOut` equals exactly `(x + m*q) / 2^(32*N_WORDS)` with `m = (x * (-q^-1)) mod 2^(32*N_WORDS)`. This value lies in `[0, 2q)` for every `0 <= x <= (2q-1)^2`, and no subtraction of `q` is ever applied, including when the value is `q` or above.
- R5: `done` is high for exactly one cycle. The new result is on `zOut` in that cycle and in the cycles after it.
- R6: `done` rises right after the `N_WORDS*N_WORDS + 3*N_WORDS`-th rising edge that follows the edge accepting `start`, independent of operand values.
- R7: While a reduction runs, `start` and all operand inputs are ignored. Holding `start` high and changing `xIn`, `qIn` and `muIn` during the run alters neither the result nor the latency.
- R8: `zOut` keeps the previous result during a following reduction and changes only on the edge where `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a reduction; captures the operands |
| xIn | input | 2*N_WORDS*32 | Double-width value to reduce, word 0 in the low bits |
| qIn | input | N_WORDS*32 | Odd modulus, word 0 in the low bits |
| muIn | input | 32 | `-q^-1 mod 2^32` |
| busy | output | 1 | A reduction is in progress |
| done | output | 1 | One-cycle completion strobe |
| zOut | output | N_WORDS*32 | Reduced result in `[0, 2q)` |

## Verification
The bench builds the engine with `N_WORDS = 3`, a word count that is not a power of two. Index arithmetic that only works for power-of-two sizes therefore shows up as wrong results. This word count still gives every column kind: empty, partial and full partial-product runs, and the top column that has no products. Moduli range from the smallest allowed top word to the largest value under the `4q` limit. Together with the extreme inputs `0` and `(2q-1)^2`, this produces many results in `[q, 2q)`. Those results show whether a hidden subtraction of `q` is taking place.

// File: rtl/mred_pkg.sv
package mred_pkg;

  // Strobes issued by the sequencer to the arithmetic datapath, one cycle each.
  typedef struct packed {
    logic load;      // capture operands, clear accumulator
    logic mac;       // acc += z[j] * q[k]
    logic addX;      // acc += x[col]
    logic writeLow;  // with addX: emit low word to z[col-N], shift acc
    logic mulMu;     // z[col] = low(acc.low * mu)
    logic zq;        // acc = (acc + z[col] * q[0]) >> word
    logic capture;   // copy finished result into the output register
  } mredCmd_t;

endpackage

// File: rtl/mred_ctrl.sv
module mred_ctrl
  import mred_pkg::*;
#(
  parameter int N_WORDS = 4,
  localparam int IDX_W  = $clog2(N_WORDS),
  localparam int CIDX_W = $clog2(2 * N_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output mredCmd_t          cmd,
  output logic [CIDX_W-1:0] colIdx,
  output logic [IDX_W-1:0]  jIdx,
  output logic [IDX_W-1:0]  kIdx,
  output logic              busy,
  output logic              done
);

  typedef enum logic [2:0] {
    S_IDLE, S_MAC, S_ADDX, S_MULMU, S_ZQ, S_FIN
  } state_t;

  localparam int LAST_COL = 2 * N_WORDS - 1;

  state_t            state, nextState;
  logic [CIDX_W-1:0] colReg, nextCol;
  logic [IDX_W-1:0]  jReg, nextJ;

  int colInt;
  int succCol;
  state_t succState;
  logic [IDX_W-1:0] succJ;

  function automatic int firstJ(int c);
    return (c < N_WORDS) ? 0 : c - N_WORDS + 1;
  endfunction

  function automatic int lastJ(int c);
    return (c < N_WORDS) ? c - 1 : N_WORDS - 1;
  endfunction

  function automatic bit colHasMac(int c);
    return (c > 0) && (c < LAST_COL);
  endfunction

  assign colInt    = int'(colReg);
  assign succCol   = colInt + 1;
  assign succState = colHasMac(succCol) ? S_MAC : S_ADDX;
  assign succJ     = IDX_W'(firstJ(succCol));

  always_comb begin
    nextState = state;
    nextCol   = colReg;
    nextJ     = jReg;
    cmd       = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          cmd.load  = 1'b1;
          nextCol   = '0;
          nextJ     = '0;
          nextState = S_ADDX;   // column 0 holds no partial products
        end
      end
      S_MAC: begin
        cmd.mac = 1'b1;
        if (int'(jReg) == lastJ(colInt)) nextState = S_ADDX;
        else                             nextJ     = jReg + 1'b1;
      end
      S_ADDX: begin
        cmd.addX = 1'b1;
        if (colInt < N_WORDS) begin
          nextState = S_MULMU;
        end else begin
          cmd.writeLow = 1'b1;
          if (colInt == LAST_COL) begin
            cmd.capture = 1'b1;
            nextState   = S_FIN;
          end else begin
            nextCol   = CIDX_W'(succCol);
            nextJ     = succJ;
            nextState = succState;
          end
        end
      end
      S_MULMU: begin
        cmd.mulMu = 1'b1;
        nextState = S_ZQ;
      end
      S_ZQ: begin
        cmd.zq    = 1'b1;
        nextCol   = CIDX_W'(succCol);
        nextJ     = succJ;
        nextState = succState;
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      colReg <= '0;
      jReg   <= '0;
    end else begin
      state  <= nextState;
      colReg <= nextCol;
      jReg   <= nextJ;
    end
  end

  assign colIdx = colReg;
  assign jIdx   = jReg;
  assign kIdx   = IDX_W'(colInt - int'(jReg));
  assign busy   = (state == S_MAC) || (state == S_ADDX) ||
                  (state == S_MULMU) || (state == S_ZQ);
  assign done   = (state == S_FIN);

endmodule

// File: rtl/mred_datapath.sv
module mred_datapath
  import mred_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 32,
  localparam int IDX_W  = $clog2(N_WORDS),
  localparam int CIDX_W = $clog2(2 * N_WORDS),
  localparam int ACC_W  = 3 * WORD_W,
  localparam int PROD_W = 2 * WORD_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mredCmd_t                    cmd,
  input  logic [CIDX_W-1:0]           colIdx,
  input  logic [IDX_W-1:0]            jIdx,
  input  logic [IDX_W-1:0]            kIdx,
  input  logic [2*N_WORDS*WORD_W-1:0] xIn,
  input  logic [N_WORDS*WORD_W-1:0]   qIn,
  input  logic [WORD_W-1:0]           muIn,
  output logic [N_WORDS*WORD_W-1:0]   zOut,
  output logic [WORD_W-1:0]           zqLowWord
);

  logic [WORD_W-1:0] xReg    [2*N_WORDS];
  logic [WORD_W-1:0] qReg    [N_WORDS];
  logic [WORD_W-1:0] zReg    [N_WORDS];
  logic [WORD_W-1:0] zOutReg [N_WORDS];
  logic [WORD_W-1:0] muReg;
  logic [ACC_W-1:0]  acc;

  logic [IDX_W-1:0]  colLow;
  logic [IDX_W-1:0]  zWrIdx;
  logic [WORD_W-1:0] mulA, mulB;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  accPlusProd;
  logic [ACC_W-1:0]  accPlusX;

  assign colLow = colIdx[IDX_W-1:0];
  assign zWrIdx = IDX_W'(colIdx - CIDX_W'(N_WORDS));

  // Single shared multiplier; operand pair chosen by the active strobe.
  always_comb begin
    mulA = zReg[jIdx];
    mulB = qReg[kIdx];
    if (cmd.mulMu) begin
      mulA = acc[WORD_W-1:0];
      mulB = muReg;
    end else if (cmd.zq) begin
      mulA = zReg[colLow];
      mulB = qReg[0];
    end
  end

  assign prod        = mulA * mulB;
  assign accPlusProd = acc + {{(ACC_W-PROD_W){1'b0}}, prod};
  assign accPlusX    = acc + {{(ACC_W-WORD_W){1'b0}}, xReg[colIdx]};
  assign zqLowWord   = accPlusProd[WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2*N_WORDS; i++) xReg[i] <= '0;
      for (int i = 0; i < N_WORDS; i++) begin
        qReg[i] <= '0;
        zReg[i] <= '0;
      end
      muReg <= '0;
      acc   <= '0;
    end else begin
      if (cmd.load) begin
        for (int i = 0; i < 2*N_WORDS; i++) xReg[i] <= xIn[i*WORD_W +: WORD_W];
        for (int i = 0; i < N_WORDS; i++)   qReg[i] <= qIn[i*WORD_W +: WORD_W];
        muReg <= muIn;
        acc   <= '0;
      end
      if (cmd.mac) acc <= accPlusProd;
      if (cmd.addX) begin
        if (cmd.writeLow) begin
          zReg[zWrIdx] <= accPlusX[WORD_W-1:0];
          acc          <= accPlusX >> WORD_W;
        end else begin
          acc <= accPlusX;
        end
      end
      if (cmd.mulMu) zReg[colLow] <= prod[WORD_W-1:0];
      if (cmd.zq)    acc <= accPlusProd >> WORD_W;
    end
  end

  // Result register: on capture, the word emitted this cycle bypasses zReg.
  for (genvar k = 0; k < N_WORDS; k++) begin : gOut
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        zOutReg[k] <= '0;
      end else if (cmd.capture) begin
        zOutReg[k] <= (zWrIdx == IDX_W'(k)) ? accPlusX[WORD_W-1:0] : zReg[k];
      end
    end
    assign zOut[k*WORD_W +: WORD_W] = zOutReg[k];
  end

endmodule

// File: rtl/mont_redc.sv
module mont_redc
  import mred_pkg::*;
#(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [2*N_WORDS*WORD_W-1:0] xIn,
  input  logic [N_WORDS*WORD_W-1:0]   qIn,
  input  logic [WORD_W-1:0]           muIn,
  output logic                        busy,
  output logic                        done,
  output logic [N_WORDS*WORD_W-1:0]   zOut
);

  localparam int IDX_W  = $clog2(N_WORDS);
  localparam int CIDX_W = $clog2(2 * N_WORDS);

  mredCmd_t          cmd;
  logic [CIDX_W-1:0] colIdx;
  logic [IDX_W-1:0]  jIdx, kIdx;
  logic [WORD_W-1:0] zqLowWord;
  logic              zqStrobe;

  assign zqStrobe = cmd.zq;

  mred_ctrl #(.N_WORDS(N_WORDS)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .cmd    (cmd),
    .colIdx (colIdx),
    .jIdx   (jIdx),
    .kIdx   (kIdx),
    .busy   (busy),
    .done   (done)
  );

  mred_datapath #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .colIdx    (colIdx),
    .jIdx      (jIdx),
    .kIdx      (kIdx),
    .xIn       (xIn),
    .qIn       (qIn),
    .muIn      (muIn),
    .zOut      (zOut),
    .zqLowWord (zqLowWord)
  );

endmodule

// File: rtl/mred_checker.sv
module mred_checker #(
  parameter int N_WORDS = 4,
  parameter int WORD_W  = 32
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      start,
  input logic                      busy,
  input logic                      done,
  input logic [N_WORDS*WORD_W-1:0] zOut,
  input logic                      zqStrobe,
  input logic [WORD_W-1:0]         zqLowWord
);

  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  // mu must cancel the accumulator low word in every reduction column
  p_low_word_cancel_r3: assert property (@(posedge clk) disable iff (!rstN)
    zqStrobe |-> (zqLowWord == '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  p_zout_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(zOut) |-> $rose(done));

endmodule

bind mont_redc mred_checker #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .zOut      (zOut),
  .zqStrobe  (zqStrobe),
  .zqLowWord (zqLowWord)
);

// File: tb/tb_mont_redc.sv
`timescale 1ns/1ps
module tb_mont_redc;

  localparam int NW  = 3;
  localparam int W   = 32;
  localparam int QW  = NW * W;
  localparam int XW  = 2 * NW * W;
  localparam int BW  = 512;
  localparam int LAT = NW * NW + 3 * NW;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [XW-1:0] xIn = '0;
  logic [QW-1:0] qIn = '0;
  logic [W-1:0]  muIn = '0;
  logic          busy, done;
  logic [QW-1:0] zOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int highHits = 0;
  logic [QW-1:0] prevZ = '0;
  bit prevValid = 1'b0;

  always #2 clk = ~clk;

  mont_redc #(.N_WORDS(NW), .WORD_W(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn), .qIn(qIn),
    .muIn(muIn), .busy(busy), .done(done), .zOut(zOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] radixMask();
    return (BW'(1) << QW) - BW'(1);
  endfunction

  // -q^-1 mod 2^(32*NW) by Newton iteration
  function automatic logic [BW-1:0] negInv(input logic [BW-1:0] q);
    logic [BW-1:0] inv = q;
    logic [BW-1:0] mask = radixMask();
    for (int it = 0; it < 10; it++)
      inv = (inv * ((BW'(2) - q * inv) & mask)) & mask;
    return (BW'(0) - inv) & mask;
  endfunction

  function automatic logic [BW-1:0] refReduce(input logic [BW-1:0] q,
                                              input logic [BW-1:0] x);
    logic [BW-1:0] m = (x * negInv(q)) & radixMask();
    return (x + m * q) >> QW;
  endfunction

  task automatic runOnce(input logic [QW-1:0] q, input logic [XW-1:0] x,
                         input bit disturb, input string tag);
    logic [BW-1:0] qB = BW'(q);
    logic [BW-1:0] xB = BW'(x);
    logic [BW-1:0] expZ = refReduce(qB, xB);
    logic [BW-1:0] zB;
    logic [QW-1:0] zHeld;
    int lat = 0;
    @(negedge clk);
    qIn = q; xIn = x; muIn = negInv(qB)[W-1:0]; start = 1'b1;
    @(negedge clk);
    start = disturb;
    check(busy === 1'b1, {tag, " R2 busy after accept"}, BW'(busy), 1);
    while (done !== 1'b1 && lat < 4 * LAT) begin
      if (disturb) begin
        xIn = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        qIn = {$urandom, $urandom, $urandom};
        muIn = $urandom;
      end
      if (prevValid && lat == 4)
        check(zOut === prevZ, {tag, " R8 previous result held"}, BW'(zOut), BW'(prevZ));
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == LAT, {tag, disturb ? " R7 R6 latency" : " R6 latency"}, BW'(lat), BW'(LAT));
    zB = BW'(zOut);
    zHeld = zOut;
    check(zB === expZ, {tag, disturb ? " R7 R4 exact result" : " R4 exact result"}, zB, expZ);
    check(zB < 2 * qB, {tag, " R4 below 2q"}, zB, 2 * qB);
    check(((zB << QW) % qB) == (xB % qB), {tag, " R3 congruence"},
          (zB << QW) % qB, xB % qB);
    if (zB >= qB) highHits++;
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R5 done single cycle"},
          BW'({busy, done}), 0);
    check(zOut === zHeld, {tag, " R5 result still valid"}, BW'(zOut), BW'(zHeld));
    prevZ = zHeld;
    prevValid = 1'b1;
  endtask

  function automatic logic [QW-1:0] randQ();
    logic [QW-1:0] q;
    q = {($urandom & 32'h3fff_ffff) | 32'h1, $urandom, $urandom};
    q[0] = 1'b1;
    return q;
  endfunction

  function automatic logic [XW-1:0] randX(input logic [QW-1:0] q);
    logic [BW-1:0] lim = (2 * BW'(q) - 1) * (2 * BW'(q) - 1) + 1;
    logic [BW-1:0] r = BW'({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    return XW'(r % lim);
  endfunction

  function automatic logic [XW-1:0] maxX(input logic [QW-1:0] q);
    return XW'((2 * BW'(q) - 1) * (2 * BW'(q) - 1));
  endfunction

  initial begin
    logic [QW-1:0] qMin;
    logic [QW-1:0] qMax;
    logic [QW-1:0] qr;
    void'($urandom(32'd20240611));
    qMin = {32'h1, 32'h0, 32'h1};
    qMax = {32'h3fff_ffff, 32'hffff_ffff, 32'hffff_ffff};

    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", BW'({busy, done}), 0);
    check(zOut === '0, "R1 zOut in reset", BW'(zOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && zOut === '0, "R1 after reset",
          BW'({busy, done}), 0);

    runOnce(qMax, '0, 1'b0, "zero input");
    runOnce(qMax, maxX(qMax), 1'b0, "max input qMax");
    runOnce(qMin, maxX(qMin), 1'b0, "max input qMin");
    runOnce(qMin, XW'(1), 1'b0, "unit input");
    runOnce(qMax, {XW{1'b0}} | XW'(qMax), 1'b0, "x equals q");

    for (int n = 0; n < 40; n++) begin
      qr = randQ();
      runOnce(qr, randX(qr), 1'b0, "random");
    end

    qr = randQ();
    runOnce(qr, randX(qr), 1'b1, "disturbed");
    runOnce(qMax, maxX(qMax), 1'b1, "disturbed max");

    check(highHits > 0, "R4 results in [q,2q) kept", BW'(highHits), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule